// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and walks the memory from power-up to a usable state. It holds the command pins in the deselected state until a clock-stable indication arrives. It then issues an unbroken run of NOP cycles for the power-up hold time. After the hold it issues one all-bank precharge, two auto-refresh commands and a mode-register load. Every command is followed by NOP cycles until its recovery time has passed.

The mode-register value comes from a 10-bit configuration word that is sampled when the load is issued. Fields the memory reserves, and the operating-mode field, are always driven as zero. A done flag rises once the load-mode recovery time has passed and stays high until reset. After that the command pins only show NOP, so a downstream controller can take over.

All waits are parameters given in clock cycles, and each must be at least 1. If the clock-stable input drops during the power-up hold, the block goes back to the deselected state and the hold starts again from zero.

Top module: `sdram_init_seq`

## Requirements
- R1: In reset, and while `clk_stable_i` has not yet been sampled high, the pins {cs_n,ras_n,cas_n,we_n} read 1111 (deselect), `addr_o` and `ba_o` are 0 and `done_o` is low. If `clk_stable_i` is sampled low during the power-up hold, the next cycle shows 1111 again and the hold count restarts from zero.
- R2: The first clock edge that samples `clk_stable_i` high starts exactly T_PWRUP consecutive NOP cycles (pins 0111). The precharge follows in the very next cycle.
- R3: The precharge is a single cycle with pins 0010, `addr_o` = 0x400 (bit 10 high selects all banks, every other bit 0) and `ba_o` = 0.
- R4: Exactly two auto-refresh cycles (pins 0001, address 0) are issued. The first comes T_RP cycles after the precharge and the second T_RFC cycles after the first. All cycles between commands are NOP with address 0.
- R5: The load-mode cycle (pins 0000, `ba_o` = 0) comes T_RFC cycles after the second refresh. In it, `addr_o[2:0]`, `addr_o[3]`, `addr_o[6:4]` and `addr_o[9]` equal the same bits of `cfg_i`, as sampled at the clock edge that starts the load cycle.
- R6: In the load-mode cycle, `addr_o[8:7]` and `addr_o[12:10]` are 0 whatever `cfg_i` holds.
- R7: `done_o` first reads high T_MRD cycles after the load-mode cycle. The cycles in between are NOP.
- R8: Once high, `done_o` stays high and the pins stay at NOP with address 0 until reset. `clk_stable_i` and `cfg_i` have no effect in this state.
- R9: If `clk_stable_i` is sampled low on the same edge that ends the last hold cycle, the restart takes priority: the next cycle shows deselect, not precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_stable_i | input | 1 | High once the memory clock is stable |
| cfg_i | input | 10 | Mode configuration word (burst length, burst type, CAS latency, write burst mode) |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
Two events can land on the same clock edge.

The first pair is a fall of `clk_stable_i` and the end of the power-up hold. The bench forces this case directly by dropping the input in the final NOP cycle. It passes if the next cycle shows deselect and no precharge is issued. Random drops at other points in the hold must also restart the count.

The second pair is a change of `cfg_i` and the edge that enters the load-mode cycle. The bench draws a new random configuration word on every cycle. It compares the load-mode address against the word that was held just before that edge, with the reserved and operating-mode bits expected as zero.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int unsigned ADDR_W = 13;
  localparam int unsigned BA_W   = 2;
  localparam int unsigned CFG_W  = 10;
  localparam int unsigned AP_BIT = 10;

  // pin order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_MRS   = 4'b0000
  } cmd_e;

  // keep burst length, burst type, CAS latency and write burst mode; zero the rest
  function automatic logic [ADDR_W-1:0] mode_word(input logic [CFG_W-1:0] cfg);
    logic [ADDR_W-1:0] w;
    w       = '0;
    w[2:0]  = cfg[2:0];
    w[3]    = cfg[3];
    w[6:4]  = cfg[6:4];
    w[9]    = cfg[9];
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned T_PWRUP = 20000,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_RFC   = 14,
  parameter int unsigned T_MRD   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_stable_i,
  output cmd_e cmd_nxt_o,
  output logic done_nxt_o
);

  localparam int unsigned T_MAX_A = (T_PWRUP > T_RP) ? T_PWRUP : T_RP;
  localparam int unsigned T_MAX_B = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int unsigned T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PRE, S_TRP, S_REF1, S_TRFC1,
    S_REF2, S_TRFC2, S_MRS, S_TMRD, S_DONE
  } st_e;

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: if (clk_stable_i) begin
        st_d  = S_PWR;
        cnt_d = '0;
      end
      S_PWR: begin
        if (!clk_stable_i) begin
          st_d  = S_IDLE;
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(T_PWRUP - 1)) begin
          st_d = S_PRE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_PRE: begin
        cnt_d = CNT_W'(1);
        st_d  = (T_RP > 1) ? S_TRP : S_REF1;
      end
      S_TRP: if (cnt_q == CNT_W'(T_RP - 1)) st_d = S_REF1;
             else cnt_d = cnt_q + 1'b1;
      S_REF1: begin
        cnt_d = CNT_W'(1);
        st_d  = (T_RFC > 1) ? S_TRFC1 : S_REF2;
      end
      S_TRFC1: if (cnt_q == CNT_W'(T_RFC - 1)) st_d = S_REF2;
               else cnt_d = cnt_q + 1'b1;
      S_REF2: begin
        cnt_d = CNT_W'(1);
        st_d  = (T_RFC > 1) ? S_TRFC2 : S_MRS;
      end
      S_TRFC2: if (cnt_q == CNT_W'(T_RFC - 1)) st_d = S_MRS;
               else cnt_d = cnt_q + 1'b1;
      S_MRS: begin
        cnt_d = CNT_W'(1);
        st_d  = (T_MRD > 1) ? S_TMRD : S_DONE;
      end
      S_TMRD: if (cnt_q == CNT_W'(T_MRD - 1)) st_d = S_DONE;
              else cnt_d = cnt_q + 1'b1;
      S_DONE: st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (st_d)
      S_IDLE:         cmd_nxt_o = CMD_DESEL;
      S_PRE:          cmd_nxt_o = CMD_PRE;
      S_REF1, S_REF2: cmd_nxt_o = CMD_REF;
      S_MRS:          cmd_nxt_o = CMD_MRS;
      default:        cmd_nxt_o = CMD_NOP;
    endcase
  end

  assign done_nxt_o = (st_d == S_DONE);

  AST_PWR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PWR && !clk_stable_i) |=> (st_q == S_IDLE)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(T_MAX)); // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DONE) |=> (st_q == S_DONE)); // R8

endmodule

// File: rtl/sdram_init_decode.sv
module sdram_init_decode
  import sdram_init_pkg::*;
(
  input  cmd_e              cmd_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  always_comb begin
    addr_o = '0;
    unique case (cmd_i)
      CMD_PRE: addr_o[AP_BIT] = 1'b1;
      CMD_MRS: addr_o = mode_word(cfg_i);
      default: addr_o = '0;
    endcase
  end

  assign ba_o = '0;

endmodule

// File: rtl/sdram_init_outreg.sv
module sdram_init_outreg
  import sdram_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_d_i,
  input  logic [ADDR_W-1:0] addr_d_i,
  input  logic [BA_W-1:0]   ba_d_i,
  input  logic              done_d_i,
  output cmd_e              cmd_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [BA_W-1:0]   ba_q_o,
  output logic              done_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q_o  <= CMD_DESEL;
      addr_q_o <= '0;
      ba_q_o   <= '0;
      done_q_o <= 1'b0;
    end else begin
      cmd_q_o  <= cmd_d_i;
      addr_q_o <= addr_d_i;
      ba_q_o   <= ba_d_i;
      done_q_o <= done_d_i;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q_o |=> done_q_o); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q_o |-> (cmd_q_o == CMD_NOP && addr_q_o == '0)); // R8
  AST_PRE_AFTER_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q_o == CMD_PRE) |-> ($past(cmd_q_o) == CMD_NOP)); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q_o == CMD_PRE) |-> addr_q_o[AP_BIT]); // R3
  AST_MODE_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q_o == CMD_MRS) |-> (addr_q_o[12:10] == 3'b000 && addr_q_o[8:7] == 2'b00)); // R6
  AST_DONE_AFTER_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q_o) |-> ($past(cmd_q_o) inside {CMD_NOP, CMD_MRS})); // R7

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned T_PWRUP = 20000,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_RFC   = 14,
  parameter int unsigned T_MRD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_stable_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  cmd_e              cmd_nxt, cmd_q;
  logic              done_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [BA_W-1:0]   ba_nxt;

  sdram_init_fsm #(
    .T_PWRUP(T_PWRUP), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clk_stable_i(clk_stable_i),
    .cmd_nxt_o   (cmd_nxt),
    .done_nxt_o  (done_nxt)
  );

  sdram_init_decode u_decode (
    .cmd_i (cmd_nxt),
    .cfg_i (cfg_i),
    .addr_o(addr_nxt),
    .ba_o  (ba_nxt)
  );

  sdram_init_outreg u_outreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_d_i (cmd_nxt),
    .addr_d_i(addr_nxt),
    .ba_d_i  (ba_nxt),
    .done_d_i(done_nxt),
    .cmd_q_o (cmd_q),
    .addr_q_o(addr_o),
    .ba_q_o  (ba_o),
    .done_q_o(done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

  localparam int TP  = 40;
  localparam int RP  = 3;
  localparam int RFC = 7;
  localparam int MRD = 4;
  localparam int K_PRE  = TP;
  localparam int K_REF1 = K_PRE + RP;
  localparam int K_REF2 = K_REF1 + RFC;
  localparam int K_MRS  = K_REF2 + RFC;
  localparam int K_DONE = K_MRS + MRD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stable = 1'b0;
  logic [9:0]  cfg = '0;
  logic        cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  pins;
  int          n_chk = 0;
  int          n_fail = 0;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always #2.5 clk = ~clk;

  sdram_init_seq #(.T_PWRUP(TP), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_stable_i(stable), .cfg_i(cfg),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .done_o(done)
  );

  function automatic logic [3:0] exp_cmd(input int k);
    if (k == K_PRE) return 4'b0010;
    if (k == K_REF1 || k == K_REF2) return 4'b0001;
    if (k == K_MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [12:0] exp_addr(input int k, input logic [9:0] c);
    if (k == K_PRE) return 13'h400;
    if (k == K_MRS) return {3'b000, c[9], 2'b00, c[6:4], c[3], c[2:0]};
    return 13'h000;
  endfunction

  function automatic string req_of(input int k);
    if (k < K_PRE) return "R2";
    if (k == K_PRE) return "R3";
    if (k < K_MRS) return "R4";
    if (k == K_MRS) return "R5";
    if (k < K_DONE) return "R7";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_desel(input string req);
    chk(pins == 4'b1111, req, 32'(pins), 32'hf);
    chk(addr == 13'h0 && ba == 2'b0, req, 32'({ba, addr}), 32'h0);
    chk(done == 1'b0, req, 32'(done), 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    stable = 1'b0;
    cfg    = 10'($urandom());
    repeat (3) @(negedge clk);
    chk_desel("R1");
    rst_n = 1'b1;
  endtask

  task automatic hold_desel(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_desel("R1");
      cfg = 10'($urandom());
    end
  endtask

  // raise stable, drop it in hold cycle g; g == TP-1 collides with the hold end
  task automatic glitch(input int g);
    stable = 1'b1;
    for (int i = 0; i <= g; i++) begin
      @(negedge clk);
      chk(pins == 4'b0111, "R2", 32'(pins), 32'h7);
      if (i == g) stable = 1'b0;
    end
    @(negedge clk);
    if (g == TP - 1) chk_desel("R9");
    else chk_desel("R1");
  endtask

  task automatic full_run();
    logic [9:0] c;
    string      r;
    stable = 1'b1;
    for (int k = 0; k <= K_DONE + 12; k++) begin
      @(negedge clk);
      c = cfg;
      r = req_of(k);
      chk(pins == exp_cmd(k), r, 32'(pins), 32'(exp_cmd(k)));
      if (k == K_MRS) begin
        chk(addr == exp_addr(k, c), "R5", 32'(addr), 32'(exp_addr(k, c)));
        chk(addr[12:10] == 3'b0 && addr[8:7] == 2'b0, "R6", 32'(addr), 32'(exp_addr(k, c)));
      end else begin
        chk(addr == exp_addr(k, c), r, 32'(addr), 32'(exp_addr(k, c)));
      end
      chk(ba == 2'b00, r, 32'(ba), 32'h0);
      chk(done == (k >= K_DONE), (k >= K_DONE - 1 && k <= K_DONE) ? "R7" : r,
          32'(done), 32'(k >= K_DONE));
      cfg = 10'($urandom());
      if (k == K_MRS - 1) cfg = 10'h3ff;  // all-ones: reserved bits must still be zero
      if (k > K_DONE) stable = 1'($urandom());
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    do_reset();
    hold_desel(5);
    glitch(0);
    hold_desel(2);
    glitch(TP - 1);
    glitch(TP / 2);
    full_run();
    for (int run = 0; run < 6; run++) begin
      do_reset();
      hold_desel($urandom_range(1, 8));
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) glitch($urandom_range(0, TP - 1));
      full_run();
    end
    do_reset();
    hold_desel(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule